// File: doc/BRIEF.md
# Bus wake-up pattern detector

The detector watches a bus-state code that a receiver front end produces once per sample clock and decides whether a remote wake-up request has arrived. A request is two wake-up symbols in a row. Each symbol is a long dominant-low (DATA_0) phase followed by a long quiet phase. The quiet phase may be idle or DATA_1. When the second symbol completes inside the allowed window, the block raises a one-cycle `wake_pulse` and sets a sticky `wake_flag`, which stays set until `wake_clr` is pulsed.

A data frame whose payload alternates runs of all-ones and all-zeros bytes can stand in for the pattern. In that case each long phase is broken up by short opposite-polarity slivers at every byte boundary. A phase filter therefore treats a run of opposite samples no longer than `GAP_TOL_CYC` as part of the phase, and does not add those samples to the phase length. A longer run ends the phase, and the phase is then judged on the length it had built up. The minimum low length, the minimum quiet length, the window for both symbols and the tolerated interruption are all parameters in sample cycles.

The control is a five-state machine:
- `ST_SEARCH`: waiting for a low phase.
- `ST_LOW1`: first DATA_0 phase.
- `ST_HIGH1`: first quiet phase.
- `ST_LOW2`: second DATA_0 phase.
- `ST_HIGH2`: second quiet phase.

Its transitions are:
- SEARCH→LOW1 (start): a low phase is recognised, and the window restarts.
- LOW1→HIGH1 and LOW2→HIGH2 (low accepted): the low phase ends with at least `MIN_LOW_CYC` samples.
- LOW1→SEARCH and LOW2→SEARCH (low rejected): the low phase ends short.
- HIGH1→LOW2 (symbol accepted): the quiet phase ends with at least `MIN_HIGH_CYC` samples.
- HIGH1→LOW1 and HIGH2→LOW1 (re-anchor): the quiet phase ends short, so the new low phase becomes a fresh first symbol and the window restarts.
- HIGH2→SEARCH (hit): the quiet phase reaches `MIN_HIGH_CYC`.
- any→SEARCH (timeout): the window expires.

Top module: `wake_pattern_detector`

## Requirements
- R1: `bus_state` encoding: 2'b00 is idle, 2'b01 is DATA_0, 2'b10 is DATA_1. Code 2'b11 is handled exactly like idle.
- R2: Two consecutive symbols raise the wake outputs. A symbol is a DATA_0 phase of at least `MIN_LOW_CYC` counted samples followed by a quiet phase of at least `MIN_HIGH_CYC` counted samples. A phase exactly at its minimum is valid.
- R3: A DATA_1 phase is accepted in place of an idle phase, with the same minimum length.
- R4: A run of at most `GAP_TOL_CYC` consecutive opposite-polarity samples inside a phase does not end it, and such samples are not counted toward the phase length.
- R5: A run of `GAP_TOL_CYC`+1 opposite samples ends the phase. A low phase that ended with fewer than `MIN_LOW_CYC` counted samples returns the detector to search and gives no wake.
- R6: Both symbols must complete within `WINDOW_CYC` cycles of the first low phase being recognised. Otherwise detection restarts and no wake is given.
- R7: A quiet phase that ends below `MIN_HIGH_CYC` does not abort detection. The low phase that ended it is taken as a new first symbol.
- R8: `wake_pulse` is high for exactly one cycle. It rises in the second cycle after the clock edge that samples the `MIN_HIGH_CYC`-th quiet sample of the second symbol.
- R9: `wake_flag` is set together with `wake_pulse` and holds until a `wake_clr` pulse. It is cleared in the cycle after `wake_clr`, and a simultaneous set wins.
- R10: While `rst_n` is low, `wake_flag` and `wake_pulse` are 0 and the detector is in search with all counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_state | input | 2 | Sampled bus level code (R1 encoding) |
| wake_clr | input | 1 | One-cycle request to clear the wake flag |
| wake_flag | output | 1 | Sticky wake indication |
| wake_pulse | output | 1 | One-cycle strobe when a pattern completes |

## Verification
The hardest situation to reach is the re-anchor path. A short quiet phase is ended by a low phase, and that same low phase has to become a valid first symbol. The timing only differs from a plain abort by one lost edge. The stimulus drives a first quiet phase one sample below its minimum, followed by two complete symbols, so a wake arrives only when the re-anchor works. Interrupted phases built from 8-sample chunks with gaps of exactly the tolerated length, and a gap one sample longer, cover both sides of the tolerance.

// File: rtl/wake_det_pkg.sv
package wake_det_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'b00,
        BUS_DATA0 = 2'b01,
        BUS_DATA1 = 2'b10,
        BUS_RSVD  = 2'b11
    } bus_code_e;

    typedef enum logic [2:0] {
        ST_SEARCH = 3'd0,
        ST_LOW1   = 3'd1,
        ST_HIGH1  = 3'd2,
        ST_LOW2   = 3'd3,
        ST_HIGH2  = 3'd4
    } det_state_e;

endpackage

// File: rtl/wake_phase_filter.sv
module wake_phase_filter #(
    parameter int GAP_TOL = 3,
    parameter int RUN_MAX = 20,
    localparam int RUN_W = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_low,
    output logic             lvl_low,
    output logic [RUN_W-1:0] run_len,
    output logic             flip
);
    localparam int GAP_W = $clog2(GAP_TOL + 2);
    localparam logic [GAP_W-1:0] GAP_MAX_V = GAP_W'(GAP_TOL);
    localparam logic [RUN_W-1:0] RUN_MAX_V = RUN_W'(RUN_MAX);
    localparam logic [RUN_W-1:0] RUN_NEW_V = RUN_W'(GAP_TOL + 1);

    logic             lvl_q;
    logic [RUN_W-1:0] run_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
            gap_q <= '0;
        end else if (sample_low == lvl_q) begin
            gap_q <= '0;
            if (run_q != RUN_MAX_V) begin
                run_q <= run_q + 1'b1;
            end
        end else if (gap_q == GAP_MAX_V) begin
            lvl_q <= sample_low;
            run_q <= RUN_NEW_V;
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign flip    = (sample_low != lvl_q) && (gap_q == GAP_MAX_V);
    assign lvl_low = lvl_q;
    assign run_len = run_q;

    // a level change only after a full run of opposite samples
    assert_flip_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(gap_q) == GAP_MAX_V));

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX_V);

endmodule

// File: rtl/wake_window_timer.sv
module wake_window_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (active && (cnt_q != LAST_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = active && !restart && (cnt_q == LAST_V);

    assert_count_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/wake_flag_stage.sv
module wake_flag_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic flag,
    output logic pulse
);
    logic flag_q;
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clear) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag  = flag_q;
    assign pulse = pulse_q;

    assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear) |=> flag_q);

    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!flag_q || pulse_q));

endmodule

// File: rtl/wake_pattern_detector.sv
module wake_pattern_detector #(
    parameter int MIN_LOW_CYC  = 20,
    parameter int MIN_HIGH_CYC = 20,
    parameter int WINDOW_CYC   = 256,
    parameter int GAP_TOL_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_state,
    input  logic       wake_clr,
    output logic       wake_flag,
    output logic       wake_pulse
);
    import wake_det_pkg::*;

    localparam int TH_MAX  = (MIN_LOW_CYC > MIN_HIGH_CYC) ? MIN_LOW_CYC : MIN_HIGH_CYC;
    localparam int RUN_MAX = (TH_MAX > GAP_TOL_CYC + 1) ? TH_MAX : GAP_TOL_CYC + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] LOW_TH  = RUN_W'(MIN_LOW_CYC);
    localparam logic [RUN_W-1:0] HIGH_TH = RUN_W'(MIN_HIGH_CYC);

    det_state_e       state_q;
    det_state_e       state_d;
    logic             sample_low;
    logic             lvl_low;
    logic [RUN_W-1:0] run_len;
    logic             flip;
    logic             low_ok;
    logic             high_ok;
    logic             expired;
    logic             restart;
    logic             hit;
    logic             active;

    // only DATA_0 is low; idle, DATA_1 and the spare code are quiet
    assign sample_low = (bus_code_e'(bus_state) == BUS_DATA0);

    wake_phase_filter #(
        .GAP_TOL (GAP_TOL_CYC),
        .RUN_MAX (RUN_MAX)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_low (sample_low),
        .lvl_low    (lvl_low),
        .run_len    (run_len),
        .flip       (flip)
    );

    wake_window_timer #(
        .LIMIT (WINDOW_CYC)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .active  (active),
        .expired (expired)
    );

    wake_flag_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clear (wake_clr),
        .flag  (wake_flag),
        .pulse (wake_pulse)
    );

    assign low_ok  = (run_len >= LOW_TH);
    assign high_ok = (run_len >= HIGH_TH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (flip && sample_low) state_d = ST_LOW1;
            ST_LOW1:   if (flip) state_d = low_ok ? ST_HIGH1 : ST_SEARCH;
            ST_HIGH1:  if (flip) state_d = high_ok ? ST_LOW2 : ST_LOW1;
            ST_LOW2:   if (flip) state_d = low_ok ? ST_HIGH2 : ST_SEARCH;
            ST_HIGH2: begin
                if (high_ok) begin
                    state_d = ST_SEARCH;
                end else if (flip) begin
                    state_d = ST_LOW1;
                end
            end
            default:   state_d = ST_SEARCH;
        endcase
        if (expired && !restart && !hit) begin
            state_d = ST_SEARCH;
        end
    end

    // outputs of the machine
    always_comb begin
        active  = (state_q != ST_SEARCH);
        hit     = (state_q == ST_HIGH2) && high_ok;
        restart = flip && sample_low &&
                  ((state_q == ST_SEARCH) ||
                   ((state_q == ST_HIGH1) && !high_ok) ||
                   ((state_q == ST_HIGH2) && !high_ok));
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_pulse_after_high2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(state_q) == ST_HIGH2));

    assert_timeout_to_search_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart && !hit) |=> (state_q == ST_SEARCH));

    assert_lvl_matches_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HIGH1) || (state_q == ST_HIGH2)) |-> !lvl_low);

endmodule

// File: tb/test_wake_pattern_detector.sv
`timescale 1ns/1ps
module test_wake_pattern_detector;

    localparam logic [1:0] C_IDLE = 2'b00;
    localparam logic [1:0] C_D0   = 2'b01;
    localparam logic [1:0] C_D1   = 2'b10;
    localparam logic [1:0] C_SP   = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_state = C_IDLE;
    logic       wake_clr = 1'b0;
    logic       wake_flag;
    logic       wake_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int req_cnt = 0;
    int done_cnt = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    wake_pattern_detector i_wake_pattern_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_state  (bus_state),
        .wake_clr   (wake_clr),
        .wake_flag  (wake_flag),
        .wake_pulse (wake_pulse)
    );

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: counts pulse cycles and pops expectations from the scoreboard
    always @(negedge clk) begin
        if (wake_pulse === 1'b1) pulses++;
        if (done_cnt < req_cnt) begin
            check_val(tag_q.pop_front(), pulses, exp_q.pop_front());
            pulses = 0;
            done_cnt++;
        end
    end

    task automatic drive(logic [1:0] code, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_state = code;
        end
    endtask

    task automatic symbol(logic [1:0] quiet, int nlow, int nhigh);
        drive(C_D0, nlow);
        drive(quiet, nhigh);
    endtask

    // driver side of the scoreboard: settle so the window ends, then push
    task automatic expect_wakes(string req, int n);
        drive(C_IDLE, 300);
        @(posedge clk);
        exp_q.push_back(n);
        tag_q.push_back(req);
        req_cnt++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        wake_clr = 1'b1;
        @(negedge clk);
        wake_clr = 1'b0;
        check_val("R9 flag after clear", int'(wake_flag), 0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_val("R10 reset flag", int'(wake_flag), 0);
        check_val("R10 reset pulse", int'(wake_pulse), 0);
        rst_n = 1'b1;
        drive(C_IDLE, 20);

        // R2 clean pattern with idle phases
        symbol(C_IDLE, 25, 25);
        symbol(C_IDLE, 25, 25);
        expect_wakes("R2 clean pattern", 1);
        check_val("R9 flag set", int'(wake_flag), 1);
        drive(C_IDLE, 300);
        check_val("R9 flag sticky", int'(wake_flag), 1);
        clear_flag();

        // R3 DATA_1 instead of idle
        symbol(C_D1, 25, 25);
        symbol(C_D1, 25, 25);
        expect_wakes("R3 data1 quiet phase", 1);
        clear_flag();

        // R1 spare code behaves as idle
        symbol(C_SP, 25, 25);
        symbol(C_SP, 25, 25);
        expect_wakes("R1 spare code as idle", 1);
        clear_flag();

        // R2 R8 exact minima and pulse timing
        symbol(C_IDLE, 20, 20);
        drive(C_D0, 20);
        drive(C_IDLE, 20);
        @(negedge clk);
        check_val("R8 pulse not yet", int'(wake_pulse), 0);
        @(negedge clk);
        check_val("R8 pulse cycle", int'(wake_pulse), 1);
        @(negedge clk);
        check_val("R8 pulse one cycle", int'(wake_pulse), 0);
        expect_wakes("R2 minimum lengths", 1);
        clear_flag();

        // R5 first low one short
        symbol(C_IDLE, 19, 20);
        symbol(C_IDLE, 20, 20);
        expect_wakes("R5 short low", 0);
        check_val("R5 flag stays clear", int'(wake_flag), 0);

        // R5 low phase broken by an over-long gap
        drive(C_D0, 12);
        drive(C_IDLE, 4);
        drive(C_D0, 12);
        drive(C_IDLE, 25);
        symbol(C_IDLE, 25, 25);
        expect_wakes("R5 gap too long", 0);

        // R4 phases chopped by maximal tolerated gaps
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 4; k++) begin
                drive(C_D0, 8);
                drive(C_IDLE, 3);
            end
            drive(C_D0, 8);
            for (int k = 0; k < 4; k++) begin
                drive(C_D1, 8);
                drive(C_D0, 3);
            end
            drive(C_D1, 8);
        end
        expect_wakes("R4 tolerated interruptions", 1);
        clear_flag();

        // R4 gap samples are not counted: 3 x 6 low samples stays below 20
        drive(C_D0, 6); drive(C_IDLE, 3);
        drive(C_D0, 6); drive(C_IDLE, 3);
        drive(C_D0, 6); drive(C_IDLE, 25);
        symbol(C_IDLE, 25, 25);
        expect_wakes("R4 gaps not counted", 0);

        // R6 second symbol outside the window
        symbol(C_IDLE, 25, 250);
        symbol(C_IDLE, 25, 25);
        expect_wakes("R6 window expired", 0);

        // R7 short quiet phase re-anchors on the next low
        symbol(C_IDLE, 20, 19);
        symbol(C_IDLE, 20, 20);
        symbol(C_IDLE, 20, 20);
        expect_wakes("R7 re-anchor", 1);
        check_val("R7 flag set", int'(wake_flag), 1);

        // R9 clear while flag is set, then a fresh hit
        clear_flag();
        symbol(C_IDLE, 25, 25);
        symbol(C_IDLE, 25, 25);
        symbol(C_IDLE, 25, 25);
        expect_wakes("R2 third symbol adds nothing", 1);
        check_val("R9 flag after new hit", int'(wake_flag), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule